// File: doc/BRIEF.md
# 64-bit Integer and Bit-Manipulation ALU

This block is the combinational arithmetic and logic stage of a 64-bit integer pipeline. It accepts two 64-bit source operands and a 7-bit operation code, and in the same cycle it returns a 64-bit result and a flag that says whether a conditional branch is taken. The operation code is split into classes by its top three bits. The lower bits choose the variant inside a class: word or full width, zero-extended upper word, inverted outcome, or the width to which the result is reduced.

The supported work covers shifts and rotates at both widths, operations on a single bit, addition and subtraction, scaled-index addition, signed and unsigned comparison and min/max, plain and inverted bitwise logic, byte-wise OR-combine, byte reversal, sign extension, packing, reduced-width logic results and branch-condition evaluation. The block holds no state. The surrounding pipeline registers its inputs and its outputs.

Top module: `int_bitalu`

## Requirements
- R1: Any operation code not named in R2 to R11 gives result 0 and br_taken 0. Examples are 0x08, 0x22, 0x2E, 0x33, 0x47, 0x50, 0x68-0x6F, 0x71, 0x74 and 0x7F.
- R2: Full-width shifts take their amount from src_b[5:0]. The codes are: 0x01 shifts left logically, 0x05 shifts right logically, 0x07 shifts right arithmetically, and 0x00 zero-extends src_a[31:0] before it shifts left.
- R3: 0x09 rotates src_a left and 0x0B rotates it right, both by src_b[5:0]. An amount of 0 returns src_a unchanged.
- R4: The single-bit operations index a bit with src_b[5:0]. 0x02 clears that bit of src_a, 0x03 sets it and 0x04 inverts it. 0x06 returns that bit of src_a in result bit 0 and zeros in every other bit.
- R5: Word operations form a 32-bit value and sign-extend its bit 31 into result[63:32]. The codes are: 0x10 add, 0x12 subtract, 0x18 shift left, 0x19 logical right shift of src_a[31:0], 0x1A arithmetic right shift of src_a[31:0], 0x1C rotate left and 0x1D rotate right. Shift and rotate amounts come from src_b[4:0].
- R6: 0x21 returns src_a+src_b. 0x20 adds src_b to the zero-extended src_a[31:0]. Scaled additions shift src_a left by 1, 2, 3 or 4 and add src_b, with codes 0x29, 0x2B, 0x2D and 0x2F. Codes 0x28, 0x2A and 0x2C do the same for scales 1 to 3 on the zero-extended src_a[31:0].
- R7: 0x30 returns src_a-src_b. 0x31 compares unsigned and 0x32 compares signed, each returning 1 or 0 for src_a<src_b in bit 0. 0x34 returns the unsigned maximum, 0x35 the unsigned minimum, 0x36 the signed maximum and 0x37 the signed minimum.
- R8: Bitwise logic: 0x40 AND, 0x42 OR and 0x44 XOR. The inverted forms 0x41, 0x43 and 0x45 give a&~b, a|~b and ~(a^b). 0x46 turns every nonzero byte of src_a into 0xFF and every zero byte into 0x00.
- R9: 0x48 and 0x4A sign-extend src_a from bit 7 and from bit 15. 0x49 returns {src_b[7:0],src_a[7:0]} zero-extended. 0x4B returns {src_b[15:0],src_a[15:0]} sign-extended from bit 31. 0x52 returns {src_b[31:0],src_a[31:0]}. 0x51 reverses the byte order of src_a.
- R10: Codes 0x60-0x67 apply a base function picked by bits [3:1]: 000 AND, 001 OR, 010 XOR, 011 byte OR-combine of src_a. When bit 0 is 0, only bit 0 of that value is returned. When bit 0 is 1, its low 16 bits are returned zero-extended.
- R11: The branch codes are 0x70 equal, 0x72 not equal, 0x78 signed less, 0x7A signed greater-or-equal, 0x7C unsigned less and 0x7E unsigned greater-or-equal. Bits [3:2] give the compare and bit 1 inverts it. For these codes br_taken gives the outcome and result is 0. br_taken is 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand, also the shift amount or bit index |
| op_code | input | 7 | Operation select, class in bits [6:4] |
| result | output | 64 | Computed value |
| br_taken | output | 1 | Branch outcome for branch codes |

## Verification
The block has no state, so any decode or datapath fault shows up at result or br_taken in the same cycle as the operation code that reaches it. A wrong class decode shows as nonzero data on a code that should give zero, or as a branch flag outside class 111. A wrong amount mask or extension shows as a difference that appears only for amounts above 31, or only when bit 31 of the word is set. This is why every code is swept with operands that set those bits.

// File: rtl/int_bitalu.sv
`timescale 1ns/1ps
module int_bitalu (
  input  logic [63:0] src_a,
  input  logic [63:0] src_b,
  input  logic [6:0]  op_code,
  output logic [63:0] result,
  output logic        br_taken
);
  localparam int XW = 64;
  localparam int HW = XW / 2;
  localparam int NB = XW / 8;

  logic [5:0]    amt6;
  logic [4:0]    amt5;
  logic [XW-1:0] a_uw, bitmask, rot_l, rot_r, sum, dif, orcb, rev8, base_lg;
  logic [HW-1:0] lo32, sllw_v, srlw_v, sraw_v, rolw_v, rorw_v;
  logic          lt_s, lt_u, eq;

  assign amt6    = src_b[5:0];
  assign amt5    = src_b[4:0];
  assign a_uw    = {{HW{1'b0}}, src_a[HW-1:0]};
  assign lo32    = src_a[HW-1:0];
  assign bitmask = {{XW-1{1'b0}}, 1'b1} << amt6;
  assign rot_l   = (src_a << amt6) | (src_a >> (7'd64 - {1'b0, amt6}));
  assign rot_r   = (src_a >> amt6) | (src_a << (7'd64 - {1'b0, amt6}));
  assign sllw_v  = lo32 << amt5;
  assign srlw_v  = lo32 >> amt5;
  assign sraw_v  = $signed(lo32) >>> amt5;
  assign rolw_v  = (lo32 << amt5) | (lo32 >> (6'd32 - {1'b0, amt5}));
  assign rorw_v  = (lo32 >> amt5) | (lo32 << (6'd32 - {1'b0, amt5}));
  assign sum     = src_a + src_b;
  assign dif     = src_a - src_b;
  assign lt_s    = $signed(src_a) < $signed(src_b);
  assign lt_u    = src_a < src_b;
  assign eq      = src_a == src_b;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign orcb[8*i +: 8]        = {8{|src_a[8*i +: 8]}};
    assign rev8[8*(NB-1-i) +: 8] = src_a[8*i +: 8];
  end

  function automatic logic [XW-1:0] sx32(input logic [HW-1:0] w);
    return {{HW{w[HW-1]}}, w};
  endfunction

  always_comb begin
    case (op_code[3:1])
      3'd0:    base_lg = src_a & src_b;
      3'd1:    base_lg = src_a | src_b;
      3'd2:    base_lg = src_a ^ src_b;
      3'd3:    base_lg = orcb;
      default: base_lg = '0;
    endcase
  end

  always_comb begin
    result = '0;
    case (op_code)
      7'h00: result = a_uw << amt6;
      7'h01: result = src_a << amt6;
      7'h02: result = src_a & ~bitmask;
      7'h03: result = src_a | bitmask;
      7'h04: result = src_a ^ bitmask;
      7'h05: result = src_a >> amt6;
      7'h06: result = {{XW-1{1'b0}}, src_a[amt6]};
      7'h07: result = $signed(src_a) >>> amt6;
      7'h09: result = rot_l;
      7'h0B: result = rot_r;
      7'h10: result = sx32(sum[HW-1:0]);
      7'h12: result = sx32(dif[HW-1:0]);
      7'h18: result = sx32(sllw_v);
      7'h19: result = sx32(srlw_v);
      7'h1A: result = sx32(sraw_v);
      7'h1C: result = sx32(rolw_v);
      7'h1D: result = sx32(rorw_v);
      7'h20: result = a_uw + src_b;
      7'h21: result = sum;
      7'h28: result = (a_uw << 1) + src_b;
      7'h29: result = (src_a << 1) + src_b;
      7'h2A: result = (a_uw << 2) + src_b;
      7'h2B: result = (src_a << 2) + src_b;
      7'h2C: result = (a_uw << 3) + src_b;
      7'h2D: result = (src_a << 3) + src_b;
      7'h2F: result = (src_a << 4) + src_b;
      7'h30: result = dif;
      7'h31: result = {{XW-1{1'b0}}, lt_u};
      7'h32: result = {{XW-1{1'b0}}, lt_s};
      7'h34: result = lt_u ? src_b : src_a;
      7'h35: result = lt_u ? src_a : src_b;
      7'h36: result = lt_s ? src_b : src_a;
      7'h37: result = lt_s ? src_a : src_b;
      7'h40: result = src_a & src_b;
      7'h41: result = src_a & ~src_b;
      7'h42: result = src_a | src_b;
      7'h43: result = src_a | ~src_b;
      7'h44: result = src_a ^ src_b;
      7'h45: result = ~(src_a ^ src_b);
      7'h46: result = orcb;
      7'h48: result = {{XW-8{src_a[7]}}, src_a[7:0]};
      7'h49: result = {{XW-16{1'b0}}, src_b[7:0], src_a[7:0]};
      7'h4A: result = {{XW-16{src_a[15]}}, src_a[15:0]};
      7'h4B: result = sx32({src_b[15:0], src_a[15:0]});
      7'h51: result = rev8;
      7'h52: result = {src_b[HW-1:0], src_a[HW-1:0]};
      7'h60, 7'h62, 7'h64, 7'h66: result = {{XW-1{1'b0}}, base_lg[0]};
      7'h61, 7'h63, 7'h65, 7'h67: result = {{XW-16{1'b0}}, base_lg[15:0]};
      default: result = '0;
    endcase
  end

  always_comb begin
    br_taken = 1'b0;
    if (op_code[6:4] == 3'b111 && !op_code[0]) begin
      case (op_code[3:2])
        2'b00:   br_taken = eq   ^ op_code[1];
        2'b10:   br_taken = lt_s ^ op_code[1];
        2'b11:   br_taken = lt_u ^ op_code[1];
        default: br_taken = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/int_bitalu_chk.sv
`timescale 1ns/1ps
module int_bitalu_chk (
  input logic [63:0] src_a,
  input logic [63:0] src_b,
  input logic [6:0]  op_code,
  input logic [63:0] result,
  input logic        br_taken
);
  always_comb begin
    if (op_code[6:4] != 3'b111)
      p_flag_only_branch_r11: assert (!br_taken) else $error("br_taken outside branch class");
    if (op_code[6:4] == 3'b111)
      p_branch_result_zero_r11: assert (result == 64'd0) else $error("branch code drove data");
    if (op_code == 7'h70)
      p_beq_matches_r11: assert (br_taken == (src_a == src_b)) else $error("beq outcome");
    if (op_code == 7'h72)
      p_bne_matches_r11: assert (br_taken != (src_a == src_b)) else $error("bne outcome");
    if (op_code[6:4] == 3'b001)
      p_word_sext_r5: assert (result[63:32] == {32{result[31]}}) else $error("word not sign-extended");
    if (op_code[6:4] == 3'b110 && !op_code[0])
      p_lsb_only_r10: assert (result[63:1] == 63'd0) else $error("lsb form wide");
    if (op_code[6:4] == 3'b110 && op_code[0])
      p_zexth_r10: assert (result[63:16] == 48'd0) else $error("zexth form wide");
    if (op_code == 7'h31 || op_code == 7'h32 || op_code == 7'h06)
      p_flag_bit0_r7: assert (result[63:1] == 63'd0) else $error("compare result wide");
  end
endmodule

bind int_bitalu int_bitalu_chk u_chk (
  .src_a(src_a), .src_b(src_b), .op_code(op_code), .result(result), .br_taken(br_taken)
);

// File: tb/tb_int_bitalu.sv
`timescale 1ns/1ps
module tb_int_bitalu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [63:0] src_a, src_b, result;
  logic [6:0]  op_code;
  logic        br_taken;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  int_bitalu dut (.src_a(src_a), .src_b(src_b), .op_code(op_code), .result(result), .br_taken(br_taken));

  typedef struct packed {
    logic [6:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] r;
    logic        t;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{7'h21, 64'd5, 64'd7, 64'd12, 1'b0},
    '{7'h30, 64'd5, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0},
    '{7'h10, 64'h7FFF_FFFF, 64'd1, 64'hFFFF_FFFF_8000_0000, 1'b0},
    '{7'h32, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd1, 1'b0},
    '{7'h31, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 1'b0},
    '{7'h06, 64'h8000_0000_0000_0000, 64'd63, 64'd1, 1'b0},
    '{7'h03, 64'd0, 64'h45, 64'h20, 1'b0},
    '{7'h09, 64'h8000_0000_0000_0001, 64'd1, 64'd3, 1'b0},
    '{7'h0B, 64'd1, 64'd4, 64'h1000_0000_0000_0000, 1'b0},
    '{7'h51, 64'h0123_4567_89AB_CDEF, 64'd0, 64'hEFCD_AB89_6745_2301, 1'b0},
    '{7'h46, 64'h0000_0100_0000_0080, 64'd0, 64'h0000_FF00_0000_00FF, 1'b0},
    '{7'h2C, 64'hFFFF_FFFF_0000_0002, 64'd1, 64'h11, 1'b0},
    '{7'h1A, 64'h8000_0000, 64'd4, 64'hFFFF_FFFF_F800_0000, 1'b0},
    '{7'h4B, 64'h1234, 64'h8765, 64'hFFFF_FFFF_8765_1234, 1'b0},
    '{7'h7A, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 1'b0},
    '{7'h7E, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 1'b1},
    '{7'h65, 64'hFFFF_FFFF_FFFF_1234, 64'd0, 64'h1234, 1'b0},
    '{7'h60, 64'd3, 64'd1, 64'd1, 1'b0},
    '{7'h22, 64'd5, 64'd7, 64'd0, 1'b0},
    '{7'h48, 64'h80, 64'd0, 64'hFFFF_FFFF_FFFF_FF80, 1'b0},
    '{7'h1C, 64'h8000_0001, 64'd1, 64'd3, 1'b0},
    '{7'h05, 64'h10, 64'h41, 64'd8, 1'b0},
    '{7'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd4, 64'h0000_000F_FFFF_FFF0, 1'b0},
    '{7'h35, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd1, 1'b0},
    '{7'h37, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    '{7'h70, 64'd9, 64'd9, 64'd0, 1'b1}
  };

  localparam logic [63:0] CORN [8] = '{
    64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000,
    64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000, 64'd63, 64'h20
  };

  function automatic bit is_listed(input logic [6:0] o);
    case (o)
      7'h00, 7'h01, 7'h02, 7'h03, 7'h04, 7'h05, 7'h06, 7'h07, 7'h09, 7'h0B,
      7'h10, 7'h12, 7'h18, 7'h19, 7'h1A, 7'h1C, 7'h1D,
      7'h20, 7'h21, 7'h28, 7'h29, 7'h2A, 7'h2B, 7'h2C, 7'h2D, 7'h2F,
      7'h30, 7'h31, 7'h32, 7'h34, 7'h35, 7'h36, 7'h37,
      7'h40, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45, 7'h46, 7'h48, 7'h49, 7'h4A, 7'h4B,
      7'h51, 7'h52, 7'h60, 7'h61, 7'h62, 7'h63, 7'h64, 7'h65, 7'h66, 7'h67,
      7'h70, 7'h72, 7'h78, 7'h7A, 7'h7C, 7'h7E: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [6:0] o);
    if (!is_listed(o)) return "R1";
    case (o[6:4])
      3'd0: begin
        if (o == 7'h09 || o == 7'h0B) return "R3";
        if (o inside {7'h02, 7'h03, 7'h04, 7'h06}) return "R4";
        return "R2";
      end
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return (o < 7'h48) ? "R8" : "R9";
      3'd5: return "R9";
      3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [63:0] m_orcb(input logic [63:0] x);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = (x[8*k +: 8] != 8'd0) ? 8'hFF : 8'h00;
    return r;
  endfunction

  function automatic logic [63:0] m_rot(input logic [63:0] x, input int n, input bit left);
    logic [63:0] r = x;
    for (int k = 0; k < n; k++) r = left ? {r[62:0], r[63]} : {r[0], r[63:1]};
    return r;
  endfunction

  function automatic logic [31:0] m_rotw(input logic [31:0] x, input int n, input bit left);
    logic [31:0] r = x;
    for (int k = 0; k < n; k++) r = left ? {r[30:0], r[31]} : {r[0], r[31:1]};
    return r;
  endfunction

  function automatic logic [64:0] model(input logic [6:0] o, input logic [63:0] x, input logic [63:0] y);
    logic [63:0] r = 64'd0;
    logic [63:0] xz = {32'd0, x[31:0]};
    logic [31:0] w = 32'd0;
    logic t = 1'b0;
    int n6 = int'(y[5:0]);
    int n5 = int'(y[4:0]);
    logic sl = $signed(x) < $signed(y);
    logic ul = x < y;
    bit word = 1'b0;
    case (o)
      7'h00: r = xz << n6;
      7'h01: r = x << n6;
      7'h02: begin r = x; r[n6] = 1'b0; end
      7'h03: begin r = x; r[n6] = 1'b1; end
      7'h04: begin r = x; r[n6] = ~x[n6]; end
      7'h05: r = x >> n6;
      7'h06: r = {63'd0, x[n6]};
      7'h07: for (int k = 0; k < 64; k++) r[k] = (k + n6 > 63) ? x[63] : x[k + n6];
      7'h09: r = m_rot(x, n6, 1'b1);
      7'h0B: r = m_rot(x, n6, 1'b0);
      7'h10: begin w = x[31:0] + y[31:0]; word = 1'b1; end
      7'h12: begin w = x[31:0] - y[31:0]; word = 1'b1; end
      7'h18: begin w = x[31:0] << n5; word = 1'b1; end
      7'h19: begin w = x[31:0] >> n5; word = 1'b1; end
      7'h1A: begin for (int k = 0; k < 32; k++) w[k] = (k + n5 > 31) ? x[31] : x[k + n5]; word = 1'b1; end
      7'h1C: begin w = m_rotw(x[31:0], n5, 1'b1); word = 1'b1; end
      7'h1D: begin w = m_rotw(x[31:0], n5, 1'b0); word = 1'b1; end
      7'h20: r = xz + y;
      7'h21: r = x + y;
      7'h28: r = xz * 2 + y;
      7'h29: r = x * 2 + y;
      7'h2A: r = xz * 4 + y;
      7'h2B: r = x * 4 + y;
      7'h2C: r = xz * 8 + y;
      7'h2D: r = x * 8 + y;
      7'h2F: r = x * 16 + y;
      7'h30: r = x + ~y + 64'd1;
      7'h31: r = ul ? 64'd1 : 64'd0;
      7'h32: r = sl ? 64'd1 : 64'd0;
      7'h34: r = ul ? y : x;
      7'h35: r = ul ? x : y;
      7'h36: r = sl ? y : x;
      7'h37: r = sl ? x : y;
      7'h40: r = x & y;
      7'h41: r = x & ~y;
      7'h42: r = x | y;
      7'h43: r = x | ~y;
      7'h44: r = x ^ y;
      7'h45: r = x ~^ y;
      7'h46: r = m_orcb(x);
      7'h48: r = 64'($signed(x[7:0]));
      7'h49: r = {48'd0, y[7:0], x[7:0]};
      7'h4A: r = 64'($signed(x[15:0]));
      7'h4B: begin w = {y[15:0], x[15:0]}; word = 1'b1; end
      7'h51: for (int k = 0; k < 8; k++) r[8*k +: 8] = x[8*(7-k) +: 8];
      7'h52: r = {y[31:0], x[31:0]};
      7'h60: r = {63'd0, x[0] & y[0]};
      7'h61: r = {48'd0, x[15:0] & y[15:0]};
      7'h62: r = {63'd0, x[0] | y[0]};
      7'h63: r = {48'd0, x[15:0] | y[15:0]};
      7'h64: r = {63'd0, x[0] ^ y[0]};
      7'h65: r = {48'd0, x[15:0] ^ y[15:0]};
      7'h66: r = {63'd0, x[7:0] != 8'd0};
      7'h67: r = {48'd0, m_orcb(x) & 64'hFFFF};
      7'h70: t = (x == y);
      7'h72: t = (x != y);
      7'h78: t = sl;
      7'h7A: t = !sl;
      7'h7C: t = ul;
      7'h7E: t = !ul;
      default: r = 64'd0;
    endcase
    if (word) r = {{32{w[31]}}, w};
    return {t, r};
  endfunction

  task automatic check(input string req, input logic [6:0] o, input logic [63:0] x,
                       input logic [63:0] y, input logic [63:0] er, input logic et);
    @(posedge clk);
    op_code = o; src_a = x; src_b = y;
    @(negedge clk);
    checks++;
    if (result !== er || br_taken !== et) begin
      fails++;
      $display("FAIL %s op=%h a=%h b=%h actual r=%h t=%b expected r=%h t=%b",
               req, o, x, y, result, br_taken, er, et);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [64:0] m;
    op_code = 7'h00; src_a = 64'd0; src_b = 64'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (result !== 64'd0 || br_taken !== 1'b0) begin
      fails++;
      $display("FAIL R2 reset-state actual r=%h t=%b expected r=0 t=0", result, br_taken);
    end

    for (int i = 0; i < NV; i++)
      check(req_of(TBL[i].op), TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].r, TBL[i].t);

    // R1 and every listed code R2..R11 against the model over corner operands
    for (int o = 0; o < 128; o++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          m = model(7'(o), CORN[i], CORN[j]);
          check(req_of(7'(o)), 7'(o), CORN[i], CORN[j], m[63:0], m[64]);
        end
      end
      for (int k = 0; k < 16; k++) begin
        logic [63:0] ra, rb;
        ra = {$urandom, $urandom};
        rb = (k < 4) ? ra : {$urandom, $urandom};
        m = model(7'(o), ra, rb);
        check(req_of(7'(o)), 7'(o), ra, rb, m[63:0], m[64]);
      end
    end

    // R3 zero rotate amount returns the operand
    check("R3", 7'h09, 64'h0123_4567_89AB_CDEF, 64'h40, 64'h0123_4567_89AB_CDEF, 1'b0);
    check("R3", 7'h0B, 64'h0123_4567_89AB_CDEF, 64'd0, 64'h0123_4567_89AB_CDEF, 1'b0);
    // R5 word shift ignores src_b[5]
    check("R5", 7'h18, 64'd1, 64'h21, 64'd2, 1'b0);
    // R6 scale-by-16 path
    check("R6", 7'h2F, 64'd3, 64'd2, 64'd50, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule